// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block collects performance statistics for a memory controller. It has a bank of general event counters and one wide free-running cycle counter, all reached through a simple 32-bit register port. Each general counter has its own 8-bit selector. The selector carries an enable flag and a 6-bit code, and the code picks one line of a 64-wide event vector that the controller drives.

Software starts, stops and clears all counting at once through one control word. A counter's start value is loaded indirectly. Software first writes a target code into a test-select register, then writes the value into a shared preload register. When a general counter wraps past its maximum it emits a one-cycle overflow pulse on its own line. A separate interrupt block consumes those pulses.

Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `evc_bank`

## Requirements
- R1: After reset every counter, selector, the test-select register and the run state are zero, and all mapped registers read back as zero.
- R2: A control write (offset 0xC00) with bit 0 set starts counting and one with bit 1 set stops it. While started, the cycle counter advances by one on every clock.
- R3: A control write with bit 2 set clears all general counters, the cycle counter and the run state. Bit 2 wins over bits 0 and 1 in the same write, and bit 1 wins over bit 0.
- R4: The selector of counter n is the byte at bits 8*(n%4)+7:8*(n%4) of the word at 0xC68+4*(n/4). Within it, bit 7 is the enable and bits 5:0 are the event code. All 8 bits read back as written.
- R5: A general counter adds one at a clock edge when the unit is started, its enable is 1, and event line [code] is high in that cycle.
- R6: A general counter holds its value when its enable is 0 or the unit is stopped, whatever the event lines do.
- R7: General counter n reads at 0xC78+4*n. After the test-select register (0xC08, 8 bits) is written with 19+n, a write to the preload register (0xC0C) loads the written value into counter n only.
- R8: A preload write while test-select holds a value outside 19..34 (for example 0 or 35) changes no counter.
- R9: If a preload write and a counting event hit the same counter in the same cycle, the loaded value is kept without the increment.
- R10: A general counter goes from 0xFFFFFFFF to 0. Its bit of the overflow output is high for exactly the one cycle after that edge, while the counter reads 0.
- R11: The 56-bit cycle counter reads as bits 55:32 in bits 23:0 of offset 0xC10 (upper bits zero) and bits 31:0 at offset 0xC14.
- R12: Reads of unmapped offsets return zero, and writes to the counter addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access valid (writes only) |
| bus_we | input | 1 | Write strobe qualifier |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 64 | Event lines from the memory controller |
| ovf_pulse | output | 16 | Per-counter overflow pulses |

## Verification
Two functions can land on the same counter in one cycle: a preload write and a qualifying event. The bench provokes this by holding the selected event line high during the preload write. It then judges the counter by the loaded value, not the value plus one.

Control writes that set clear together with start or stop are also issued while the unit runs. After such a write, the bench checks that all counts are zero and that the cycle counter stays still.

Long stretches of random event vectors under random selectors are compared against a cycle-exact model kept in the bench. Directed preloads just under the maximum drive the wrap and overflow pulse.

// File: rtl/evc_pkg.sv
package evc_pkg;

   // Register byte offsets; software depends on these positions.
   localparam logic [11:0] OFF_CTRL    = 12'hC00;
   localparam logic [11:0] OFF_TSEL    = 12'hC08;
   localparam logic [11:0] OFF_PRELOAD = 12'hC0C;
   localparam logic [11:0] OFF_CYC_HI  = 12'hC10;
   localparam logic [11:0] OFF_CYC_LO  = 12'hC14;
   localparam logic [11:0] OFF_SEL0    = 12'hC68;
   localparam logic [11:0] OFF_CNT0    = 12'hC78;

   // Control word bit positions
   localparam int CTL_START = 0;
   localparam int CTL_STOP  = 1;
   localparam int CTL_CLEAR = 2;

   // Test-select code that targets general counter 0
   localparam int PRELOAD_BASE = 19;

   typedef struct packed {
      logic       en;
      logic       spare;
      logic [5:0] code;
   } sel_field_t;

endpackage

// File: rtl/evc_event_ctr.sv
module evc_event_ctr #(
   parameter int CTR_W  = 32,
   parameter int EVT_W  = 64,
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              en,
   input  logic [CODE_W-1:0] code,
   input  logic [EVT_W-1:0]  evt_vec,
   input  logic              clear,
   input  logic              load,
   input  logic [CTR_W-1:0]  load_val,
   output logic [CTR_W-1:0]  count,
   output logic              ovf
);

   generate
      if ((1 << CODE_W) < EVT_W) begin : g_bad_code
         $error("evc_event_ctr: code field too narrow for event vector");
      end
   endgenerate

   logic             hit;
   logic             at_max;
   logic [CTR_W-1:0] count_q;
   logic             ovf_q;

   assign hit    = run && en && evt_vec[code];
   assign at_max = &count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (clear) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (load) begin
         count_q <= load_val;
         ovf_q   <= 1'b0;
      end else begin
         ovf_q <= hit && at_max;
         if (hit) count_q <= count_q + 1'b1;
      end
   end

   assign count = count_q;
   assign ovf   = ovf_q;

   // R10: an overflow pulse only appears with the counter at zero
   assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (count_q == '0));

   // R6: disabled or stopped counter keeps its value
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run || !en) && !clear && !load) |=> (count_q == $past(count_q)));

   // R7: a load lands the presented value
   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> (count_q == $past(load_val)));

   // R3: clear empties the counter and its pulse
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> ((count_q == '0) && !ovf_q));

endmodule

// File: rtl/evc_cycle_ctr.sv
module evc_cycle_ctr #(
   parameter int HI_W = 24,
   parameter int LO_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 clear,
   output logic [HI_W+LO_W-1:0] value
);

   localparam int TOT_W = HI_W + LO_W;

   generate
      if (HI_W < 1 || LO_W < 1) begin : g_bad_split
         $error("evc_cycle_ctr: both halves need at least one bit");
      end
   endgenerate

   logic [TOT_W-1:0] value_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value_q <= '0;
      else if (clear)  value_q <= '0;
      else if (run)    value_q <= value_q + 1'b1;
   end

   assign value = value_q;

   // R2: one step per clock while started
   assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear) |=> (value_q == $past(value_q) + 1'b1));

   // R3: clear zeroes the cycle count
   assert_cycle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (value_q == '0));

endmodule

// File: rtl/evc_bank.sv
module evc_bank
   import evc_pkg::*;
#(
   parameter int NUM_CTR  = 16,
   parameter int CTR_W    = 32,
   parameter int EVT_W    = 64,
   parameter int CYC_HI_W = 24,
   parameter int CYC_LO_W = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [11:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [63:0]       evt_in,
   output logic [15:0]       ovf_pulse
);

   localparam int CODE_W   = $clog2(EVT_W);
   localparam int LANES    = DATA_W / 8;
   localparam int SEL_WRDS = NUM_CTR / LANES;
   localparam int CYC_W    = CYC_HI_W + CYC_LO_W;

   generate
      if (NUM_CTR % LANES != 0) begin : g_bad_lanes
         $error("evc_bank: counter count must fill whole selector words");
      end
      if (CODE_W > 6) begin : g_bad_evt
         $error("evc_bank: event vector wider than the 6-bit code");
      end
      if (CTR_W > DATA_W || CYC_LO_W != DATA_W || CYC_HI_W > DATA_W) begin : g_bad_w
         $error("evc_bank: counter widths do not fit the data word");
      end
      if (PRELOAD_BASE + NUM_CTR > 256) begin : g_bad_tsel
         $error("evc_bank: preload codes overflow the test-select field");
      end
   endgenerate

   // ---------------- write decode ----------------
   logic wr;
   logic wr_ctrl;
   logic clr_all;
   logic wr_preload;

   assign wr         = bus_en && bus_we;
   assign wr_ctrl    = wr && (bus_addr == OFF_CTRL);
   assign clr_all    = wr_ctrl && bus_wdata[CTL_CLEAR];
   assign wr_preload = wr && (bus_addr == OFF_PRELOAD);

   // ---------------- run state ----------------
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      run_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[CTL_CLEAR])        run_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[CTL_STOP])         run_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[CTL_START])        run_q <= 1'b1;
   end

   // ---------------- test select ----------------
   logic [7:0] tsel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tsel_q <= '0;
      else if (wr && bus_addr == OFF_TSEL)   tsel_q <= bus_wdata[7:0];
   end

   // ---------------- selectors ----------------
   sel_field_t sel_q [NUM_CTR];

   for (genvar w = 0; w < SEL_WRDS; w++) begin : g_selw
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(int'(OFF_SEL0) + 4 * w);
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          sel_q[w*LANES+l] <= '0;
            else if (wr && bus_addr == WADDR)    sel_q[w*LANES+l] <= bus_wdata[8*l +: 8];
         end
      end
   end

   // ---------------- general counters ----------------
   logic [CTR_W-1:0] cnt   [NUM_CTR];
   logic [NUM_CTR-1:0] ovf_vec;
   logic [NUM_CTR-1:0] load_vec;

   for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      assign load_vec[n] = wr_preload && (tsel_q == 8'(PRELOAD_BASE + n));

      evc_event_ctr #(
         .CTR_W  (CTR_W),
         .EVT_W  (EVT_W),
         .CODE_W (CODE_W)
      ) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run_q),
         .en       (sel_q[n].en),
         .code     (sel_q[n].code[CODE_W-1:0]),
         .evt_vec  (evt_in[EVT_W-1:0]),
         .clear    (clr_all),
         .load     (load_vec[n]),
         .load_val (bus_wdata[CTR_W-1:0]),
         .count    (cnt[n]),
         .ovf      (ovf_vec[n])
      );
   end

   assign ovf_pulse = 16'(ovf_vec);

   // ---------------- cycle counter ----------------
   logic [CYC_W-1:0] cyc;

   evc_cycle_ctr #(
      .HI_W (CYC_HI_W),
      .LO_W (CYC_LO_W)
   ) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .clear (clr_all),
      .value (cyc)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFF_TSEL)   bus_rdata = 32'(tsel_q);
      if (bus_addr == OFF_CYC_HI) bus_rdata = 32'(cyc[CYC_W-1:CYC_LO_W]);
      if (bus_addr == OFF_CYC_LO) bus_rdata = 32'(cyc[CYC_LO_W-1:0]);
      for (int w = 0; w < SEL_WRDS; w++) begin
         if (bus_addr == ADDR_W'(int'(OFF_SEL0) + 4 * w)) begin
            for (int l = 0; l < LANES; l++) bus_rdata[8*l +: 8] = sel_q[w*LANES+l];
         end
      end
      for (int n = 0; n < NUM_CTR; n++) begin
         if (bus_addr == ADDR_W'(int'(OFF_CNT0) + 4 * n)) bus_rdata = 32'(cnt[n]);
      end
   end

   // R7/R8: a preload reaches at most one counter, and none when the code misses
   assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_vec));

   // R3: clear also stops the unit
   assert_clear_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> !run_q);

endmodule

// File: tb/evc_bank_tb.sv
module evc_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] evt_in = '0;
   logic [15:0] ovf_pulse;

   always #4 clk = ~clk;   // 125 MHz

   evc_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_in    (evt_in),
      .ovf_pulse (ovf_pulse)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // ---------------- reference model ----------------
   logic [31:0] m_cnt [16];
   logic [7:0]  m_sel [16];
   logic [7:0]  m_tsel = '0;
   logic        m_run = 1'b0;
   logic [55:0] m_cyc = '0;
   logic [15:0] m_ovf = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void model_step(input logic [63:0] ev, input logic w,
                                      input logic [11:0] a, input logic [31:0] d);
      logic [15:0] nov = '0;
      logic clr = w && a == 12'hC00 && d[2];
      if (m_run) m_cyc = m_cyc + 56'd1;
      for (int n = 0; n < 16; n++) begin
         logic inc = m_run && m_sel[n][7] && ev[m_sel[n][5:0]];
         logic ld  = w && a == 12'hC0C && m_tsel == 8'(19 + n);
         if (clr) m_cnt[n] = '0;
         else if (ld) m_cnt[n] = d;
         else if (inc) begin
            if (m_cnt[n] == 32'hFFFF_FFFF) nov[n] = 1'b1;
            m_cnt[n] = m_cnt[n] + 32'd1;
         end
      end
      if (clr) m_cyc = '0;
      m_ovf = nov;
      if (w && a == 12'hC00) begin
         if (d[2] || d[1]) m_run = 1'b0;
         else if (d[0]) m_run = 1'b1;
      end
      if (w && a == 12'hC08) m_tsel = d[7:0];
      for (int k = 0; k < 4; k++)
         if (w && a == 12'(12'hC68 + 4 * k))
            for (int l = 0; l < 4; l++) m_sel[4*k+l] = d[8*l +: 8];
   endfunction

   // One clock: drive at the falling edge, sample before the rising edge.
   task automatic tick(input logic [63:0] ev, input logic w, input logic [11:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
      @(negedge clk);
      evt_in = ev; bus_en = w; bus_we = w; bus_addr = a; bus_wdata = d;
      #1;
      rd = bus_rdata;
      chk("R10 ovf", 64'(ovf_pulse), 64'(m_ovf));
      @(posedge clk);
      model_step(ev, w, a, d);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] rd;
      tick('0, 1'b1, a, d, rd);
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] rd;
      tick('0, 1'b0, a, '0, rd);
      chk(tag, 64'(rd), 64'(exp));
   endtask

   task automatic idle(input logic [63:0] ev, input int cyc);
      logic [31:0] rd;
      for (int i = 0; i < cyc; i++) tick(ev, 1'b0, 12'h000, '0, rd);
   endtask

   function automatic logic [11:0] cnt_a(input int n);
      return 12'(12'hC78 + 4 * n);
   endfunction

   task automatic check_all(input string tag);
      for (int n = 0; n < 16; n++) rdchk(tag, cnt_a(n), m_cnt[n]);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < 16; n++) begin m_cnt[n] = '0; m_sel[n] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R12 unmapped reads
      check_all("R1 counter");
      rdchk("R1 cyc_hi", 12'hC10, 32'h0);
      rdchk("R1 cyc_lo", 12'hC14, 32'h0);
      rdchk("R1 tsel", 12'hC08, 32'h0);
      rdchk("R1 sel", 12'hC6C, 32'h0);
      rdchk("R12 unmapped C04", 12'hC04, 32'h0);
      rdchk("R12 unmapped 100", 12'h100, 32'h0);

      // R4 selector layout and readback
      wr(12'hC68, 32'hC5_3F_85_81);
      rdchk("R4 sel readback", 12'hC68, 32'hC5_3F_85_81);
      wr(12'hC6C, 32'h00_00_00_8A);
      rdchk("R4 sel word1", 12'hC6C, 32'h00_00_00_8A);

      // R2 start, cycle counter, R11 split
      wr(12'hC00, 32'h1);
      idle(64'h0, 5);
      rdchk("R11 cyc_lo", 12'hC14, m_cyc[31:0]);
      rdchk("R11 cyc_hi", 12'hC10, {8'h0, m_cyc[55:32]});
      rdchk("R2 cyc step", 12'hC14, m_cyc[31:0]);

      // R5 counting: counter1 code 5 enabled, counter2 code 63 disabled (R6)
      for (int i = 0; i < 12; i++) idle((i % 3 == 0) ? 64'h0 : (64'h20 | 64'h8000_0000_0000_0000), 1);
      rdchk("R5 ctr1", cnt_a(1), m_cnt[1]);
      chk("R5 ctr1 count", 64'(m_cnt[1]), 64'd8);
      rdchk("R6 ctr2 disabled", cnt_a(2), 32'h0);

      // R2/R6 stopped: events have no effect, cycle frozen
      wr(12'hC00, 32'h2);
      idle(64'hFFFF_FFFF_FFFF_FFFF, 6);
      rdchk("R6 ctr1 frozen", cnt_a(1), 32'd8);
      rdchk("R2 cyc frozen", 12'hC14, m_cyc[31:0]);

      // R7 preload counter 7, neighbours untouched
      wr(12'hC08, 32'd26);
      wr(12'hC0C, 32'h1234_5678);
      rdchk("R7 ctr7", cnt_a(7), 32'h1234_5678);
      rdchk("R7 ctr6 untouched", cnt_a(6), 32'h0);
      rdchk("R7 ctr1 untouched", cnt_a(1), 32'd8);

      // R8 preload with codes out of range
      wr(12'hC08, 32'd0);
      wr(12'hC0C, 32'hDEAD_BEEF);
      wr(12'hC08, 32'd35);
      wr(12'hC0C, 32'hCAFE_F00D);
      check_all("R8 no load");

      // R12 writes to counter addresses ignored
      wr(cnt_a(7), 32'h0);
      rdchk("R12 counter write", cnt_a(7), 32'h1234_5678);

      // R9 preload vs event on counter 3 (code 5, lane 3 of word0 = C5)
      wr(12'hC08, 32'd22);
      wr(12'hC00, 32'h1);
      tick(64'h20, 1'b1, 12'hC0C, 32'h0000_0100, rd);
      rdchk("R9 load wins", cnt_a(3), 32'h0000_0100);
      chk("R9 model", 64'(m_cnt[3]), 64'h100);

      // R10 wrap on counter 4 (word1 lane0 = 8A, code 10)
      wr(12'hC00, 32'h2);
      wr(12'hC08, 32'd23);
      wr(12'hC0C, 32'hFFFF_FFFE);
      wr(12'hC00, 32'h1);
      idle(64'h400, 2);
      rdchk("R10 wrapped", cnt_a(4), 32'h0);
      chk("R10 one pulse seen", 64'(m_cnt[4]), 64'h0);
      idle(64'h0, 2);

      // R3 clear wins over start and stop while running
      idle(64'hFFFF_FFFF_FFFF_FFFF, 4);
      wr(12'hC00, 32'h7);
      check_all("R3 cleared");
      idle(64'hFFFF_FFFF_FFFF_FFFF, 3);
      rdchk("R3 cyc stays", 12'hC14, 32'h0);
      rdchk("R3 run off ctr1", cnt_a(1), 32'h0);
      wr(12'hC00, 32'h3);
      idle(64'hFFFF_FFFF_FFFF_FFFF, 3);
      rdchk("R3 stop over start", 12'hC14, 32'h0);

      // R5 random rounds
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 4; k++) wr(12'(12'hC68 + 4 * k), $urandom & 32'hBFBF_BFBF);
         if (r == 2) wr(12'hC00, 32'h5);
         wr(12'hC00, 32'h1);
         for (int i = 0; i < 300; i++) idle({$urandom, $urandom}, 1);
         rdchk("R11 random cyc_lo", 12'hC14, m_cyc[31:0]);
         wr(12'hC00, 32'h2);
         check_all("R5 random");
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule